// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Chain

This block models a row of interrupt-capable peripheral slots that share one active-low request line to a processor. Priority is set by where a slot sits in a serial enable chain. Slot 0 is at the top: its enable-in is held high. Each slot's enable-out feeds the enable-in of the slot below it. A slot that is busy (pending or in service) pulls its enable-out low. That silences every slot beneath it.

Each slot runs a three-state machine. The states are `SLOT_IDLE`, `SLOT_PEND` and `SLOT_SERV`, and the transitions between them are:

- `T_RAISE`: from idle to pending, on a local request.
- `T_TAKE`: from pending to in-service, on an acknowledge seen while enable-in is high.
- `T_RETIRE`: from in-service back to idle, on a return-from-interrupt indication seen while enable-in is high.

Each slot drives an open-drain style request output. These outputs are combined as a logical AND of the active-low values. During an acknowledge, the one eligible slot claims the cycle. The block reports which slot claimed it and that slot's vector byte.

The slot count is a parameter from 2 to 4, because ripple delay through the chain limits its length. Slot i's vector byte is `VEC_BASE + i*VEC_STEP`.

Top module: `irq_daisy_chain`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, every slot is idle. In that state `irq_n` is 1, every bit of `chain_ieo` is 1, and `ack_valid` is 0.
- R2: An idle slot whose `irq_req` bit is 1 at a rising edge becomes pending at that edge. If its enable-in is high, `irq_n` is 0 from that edge on.
- R3: `irq_n` is 0 exactly when some slot is pending with its enable-in high. It is the AND of the per-slot active-low request outputs.
- R4: `chain_ieo[i]` equals the enable-in of slot i AND (slot i idle). Slot 0's enable-in is 1, and slot i+1's enable-in is `chain_ieo[i]`. This is combinational.
- R5: A pending or in-service slot blocks every lower slot. A lower pending slot does not pull `irq_n` low and cannot claim an acknowledge.
- R6: When `ack` is 1, the pending slot i with enable-in high claims the cycle in the same cycle. `ack_valid` becomes 1, `ack_slot` equals i, and `ack_vector` equals `VEC_BASE + i*VEC_STEP` (0x10 + 8*i by default). At the next edge that slot becomes in-service.
- R7: An `ack` with no eligible pending slot gives `ack_valid` = 0 and changes no slot state.
- R8: When `reti` is 1, the in-service slot whose enable-in is high returns to idle at the edge, and the slots below it are released. `reti` has no effect on any other slot.
- R9: While a lower slot is in service, a higher slot can still become pending. It then drives `irq_n` low and can be acknowledged, which nests the service.
- R10: A request to a slot that is already pending or in service is ignored and is not queued. After `T_RETIRE` the slot is idle, even if its request was pulsed while it was being served.
- R11: At most one slot claims any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SLOTS | Local interrupt request per slot, bit i is slot i |
| ack | input | 1 | Interrupt acknowledge cycle indication |
| reti | input | 1 | Return-from-interrupt indication |
| irq_n | output | 1 | Combined active-low interrupt request |
| chain_ieo | output | NUM_SLOTS | Enable-out of each slot, bit i is slot i |
| ack_valid | output | 1 | A slot claimed the current acknowledge |
| ack_slot | output | SLOT_W | Index of the claiming slot |
| ack_vector | output | 8 | Vector byte of the claiming slot |

## Verification
The bench targets the following cases, and each would show a different failure:

- Two slots requesting at once. A chain that does not gate would let the lower slot pull `irq_n` low or claim the acknowledge.
- A higher slot interrupting a lower one that is in service. A design that blocked upward would leave `irq_n` high.
- A `reti` while two services are nested. It must release only the innermost slot, so a design that cleared every in-service slot would release the outer slot too early.
- An acknowledge with nobody eligible, and requests pulsed during service. A wrong design would report a phantom claim, or would show a queued second interrupt after return.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_SERV = 2'd2
    } slot_state_t;
endpackage

// File: rtl/irq_slot.sv
module irq_slot
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    input  logic reti,
    input  logic ien,
    output logic ieo,
    output logic int_n,
    output logic claim
);
    slot_state_t state_q;
    slot_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions T_RAISE, T_TAKE, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (req)         state_d = SLOT_PEND;
            SLOT_PEND: if (ack && ien)  state_d = SLOT_SERV;
            SLOT_SERV: if (reti && ien) state_d = SLOT_IDLE;
            default:                    state_d = SLOT_IDLE;
        endcase
    end

    always_comb begin
        ieo   = ien && (state_q == SLOT_IDLE);
        int_n = !(ien && (state_q == SLOT_PEND));
        claim = ack && ien && (state_q == SLOT_PEND);
    end

    // R2: a request seen while idle raises pending
    a_r2_raise_pend: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_IDLE && req) |=> (state_q == SLOT_PEND));

    // R6: a claim moves the slot into service
    a_r6_claim_serv: assert property (@(posedge clk) disable iff (rst)
        claim |=> (state_q == SLOT_SERV));

    // R8: reti seen with enable-in high retires the service
    a_r8_reti_release: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_SERV && reti && ien) |=> ieo == $past(ien) || state_q == SLOT_IDLE);

    // R10: service is kept (requests ignored) until retirement
    a_r10_serv_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_SERV && !(reti && ien)) |=> (state_q == SLOT_SERV));
endmodule

// File: rtl/irq_wired_and.sv
module irq_wired_and #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] drv_n,
    output logic             line_n
);
    // open-drain outputs tied together: any low pulls the line low
    assign line_n = &drv_n;
endmodule

// File: rtl/irq_claim_enc.sv
module irq_claim_enc #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned VEC_BASE  = 8'h10,
    parameter int unsigned VEC_STEP  = 8'h08,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] claim,
    output logic                 valid,
    output logic [SLOT_W-1:0]    idx,
    output logic [7:0]           vector
);
    always_comb begin
        valid  = 1'b0;
        idx    = '0;
        vector = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (claim[i]) begin
                valid  = 1'b1;
                idx    = SLOT_W'(i);
                vector = 8'(VEC_BASE + i * VEC_STEP);
            end
        end
    end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned VEC_BASE  = 8'h10,
    parameter int unsigned VEC_STEP  = 8'h08,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] irq_req,
    input  logic                 ack,
    input  logic                 reti,
    output logic                 irq_n,
    output logic [NUM_SLOTS-1:0] chain_ieo,
    output logic                 ack_valid,
    output logic [SLOT_W-1:0]    ack_slot,
    output logic [7:0]           ack_vector
);
    logic [NUM_SLOTS:0]   chain_en;
    logic [NUM_SLOTS-1:0] slot_int_n;
    logic [NUM_SLOTS-1:0] slot_claim;

    assign chain_en[0] = 1'b1;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            irq_slot u_slot (
                .clk   (clk),
                .rst   (rst),
                .req   (irq_req[g]),
                .ack   (ack),
                .reti  (reti),
                .ien   (chain_en[g]),
                .ieo   (chain_en[g+1]),
                .int_n (slot_int_n[g]),
                .claim (slot_claim[g])
            );
        end
    endgenerate

    irq_wired_and #(.WIDTH(NUM_SLOTS)) u_line (
        .drv_n  (slot_int_n),
        .line_n (irq_n)
    );

    irq_claim_enc #(
        .NUM_SLOTS (NUM_SLOTS),
        .VEC_BASE  (VEC_BASE),
        .VEC_STEP  (VEC_STEP)
    ) u_enc (
        .claim  (slot_claim),
        .valid  (ack_valid),
        .idx    (ack_slot),
        .vector (ack_vector)
    );

    assign chain_ieo = chain_en[NUM_SLOTS:1];

    // R1: reset leaves the chain open and the line released
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (irq_n && (&chain_ieo) && !ack_valid));

    // R11: a single claimant per acknowledge
    a_r11_one_claim: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_claim));

    // R3: an asserted request line always has a claimant on acknowledge
    a_r3_line_claim: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_n) |-> ack_valid);

    // R5: a claimant's enable-out blocks everything below it
    a_r5_block_below: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !chain_ieo[ack_slot]);
endmodule

// File: tb/tb_irq_daisy_chain.sv
`timescale 1ns/1ps
module tb_irq_daisy_chain;
    localparam int N    = 4;
    localparam int SW   = 2;
    localparam int VB   = 8'h10;
    localparam int VS   = 8'h08;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_req;
    logic          ack;
    logic          reti;
    logic          irq_n;
    logic [N-1:0]  chain_ieo;
    logic          ack_valid;
    logic [SW-1:0] ack_slot;
    logic [7:0]    ack_vector;

    int n_checks = 0;
    int n_fails  = 0;
    int mst [N];  // 0 idle, 1 pending, 2 in service

    always #2.5 clk = ~clk;

    irq_daisy_chain #(.NUM_SLOTS(N), .VEC_BASE(VB), .VEC_STEP(VS)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ack(ack), .reti(reti),
        .irq_n(irq_n), .chain_ieo(chain_ieo), .ack_valid(ack_valid),
        .ack_slot(ack_slot), .ack_vector(ack_vector)
    );

    function automatic logic m_ien(int i);
        logic e = 1'b1;
        for (int k = 0; k < i; k++) if (mst[k] != 0) e = 1'b0;
        return e;
    endfunction

    function automatic logic [N-1:0] m_ieo();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_ien(i) && (mst[i] == 0);
        return v;
    endfunction

    function automatic logic m_irq_n();
        logic l = 1'b1;
        for (int i = 0; i < N; i++) if (m_ien(i) && mst[i] == 1) l = 1'b0;
        return l;
    endfunction

    function automatic int m_claim();
        int c = -1;
        for (int i = 0; i < N; i++) if (ack && m_ien(i) && mst[i] == 1) c = i;
        return c;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        int nx [N];
        for (int i = 0; i < N; i++) begin
            nx[i] = mst[i];
            if (mst[i] == 0 && irq_req[i]) nx[i] = 1;
            else if (mst[i] == 1 && ack && m_ien(i)) nx[i] = 2;
            else if (mst[i] == 2 && reti && m_ien(i)) nx[i] = 0;
        end
        for (int i = 0; i < N; i++) mst[i] = nx[i];
    endtask

    task automatic step(string tag, logic [N-1:0] r, logic a, logic t);
        int c;
        @(negedge clk);
        irq_req = r; ack = a; reti = t;
        #1;
        c = m_claim();
        check({tag, " R3 irq_n"}, int'(irq_n), int'(m_irq_n()));
        check({tag, " R4 chain_ieo"}, int'(chain_ieo), int'(m_ieo()));
        check({tag, " R6/R7 ack_valid"}, int'(ack_valid), int'(c >= 0));
        if (c >= 0) begin
            check({tag, " R6 ack_slot"}, int'(ack_slot), c);
            check({tag, " R6 ack_vector"}, int'(ack_vector), (VB + c * VS) & 8'hff);
        end
        @(posedge clk);
        model_update();
    endtask

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; irq_req = '0; ack = 1'b0; reti = 1'b0;
        for (int i = 0; i < N; i++) mst[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 irq_n in reset", int'(irq_n), 1);
        check("R1 chain_ieo in reset", int'(chain_ieo), 4'hf);
        check("R1 ack_valid in reset", int'(ack_valid), 0);
        rst = 1'b0;

        step("R1 after reset", 4'b0000, 1'b0, 1'b0);
        step("R2 raise slot2", 4'b0100, 1'b0, 1'b0);
        step("R2 slot2 pending", 4'b0000, 1'b0, 1'b0);
        step("R5 slot3 blocked", 4'b1000, 1'b0, 1'b0);
        step("R5 ack picks slot2", 4'b0000, 1'b1, 1'b0);
        step("R7 ack no claimant", 4'b0000, 1'b1, 1'b0);
        step("R9 raise slot0", 4'b0001, 1'b0, 1'b0);
        step("R9 ack slot0", 4'b0000, 1'b1, 1'b0);
        step("R10 pulse slot0 in service", 4'b0001, 1'b0, 1'b0);
        step("R8 reti inner", 4'b0000, 1'b0, 1'b1);
        step("R10 slot0 idle", 4'b0000, 1'b0, 1'b0);
        step("R8 reti outer", 4'b0000, 1'b0, 1'b1);
        step("R8 slot3 released", 4'b0000, 1'b0, 1'b0);
        step("R6 ack slot3", 4'b0000, 1'b1, 1'b0);
        step("R8 reti slot3", 4'b0000, 1'b0, 1'b1);
        step("R11 all raise", 4'b1111, 1'b0, 1'b0);
        step("R11 ack slot0", 4'b0000, 1'b1, 1'b0);

        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] r;
            for (int b = 0; b < N; b++) r[b] = ($urandom % 6) == 0;
            step("R11 random", r, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule